// File: doc/BRIEF.md
# Prescaled Event Timer with Sticky Overflow

The block is an 8-bit up-counter for a small controller core. It advances on one of two event sources. In timer mode the source is the core's one-cycle instruction enable. In counter mode the source is a chosen edge of an external pin. The pin passes through a synchronizer before any edge is detected. An optional power-of-two prescaler sits between the event source and the count. Its divide ratio comes from a 3-bit code, and a bypass bit gives a 1:1 rate.

Software can preload the count through a write strobe. A preload resets the hidden prescaler to zero and locks out counting for the next two instruction cycles. Each wrap from FFh to 00h raises a sticky overflow flag. The flag stays set until software clears it. An interrupt request is raised from that flag only while the enable bit is set. A sleep input freezes counting.

Top module: `evt_timer8`

## Requirements
- R1: While rst_n is low and right after it rises, count is 00h and ovf_flag and irq are 0. The prescaler is empty.
- R2: With src_ext = 0, each clock cycle that has cyc_en = 1 is one source event. Cycles with cyc_en = 0 produce no event.
- R3: With src_ext = 1, cyc_en produces no event. ext_pin is sampled through two flops. A change of ext_pin set up before clock edge k updates count at edge k+2 (with bypass). edge_fall = 0 counts rising transitions, edge_fall = 1 counts falling transitions. Each qualifying transition yields exactly one event.
- R4: With psc_bypass = 1, every accepted event increments count. With psc_bypass = 0, the count increments once per 2^(psc_rate+1) accepted events: code 0 divides by 2 and code 7 divides by 256.
- R5: A cycle with wr_cnt = 1 loads wr_data into count at the next edge, resets the prescaler to zero and produces no increment. A write takes priority over sleep.
- R6: After a write, the next two cycles with cyc_en = 1 (and every cycle up to the second of them) accept no event. The event count resumes at the third cyc_en cycle.
- R7: Every increment from FFh to 00h sets ovf_flag, whatever the value of irq_en.
- R8: ovf_flag stays set until a cycle with flag_clr = 1. If flag_clr arrives in the same cycle as a wrap, the flag stays set.
- R9: irq is 1 exactly while ovf_flag = 1 and irq_en = 1.
- R10: While sleep = 1 and no write occurs, count and the prescaler hold their values and events are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | One-cycle instruction-cycle enable |
| ext_pin | input | 1 | External count input, asynchronous |
| sleep | input | 1 | Freezes counting while 1 |
| src_ext | input | 1 | 0: instruction cycles, 1: external pin |
| edge_fall | input | 1 | 0: rising pin edge, 1: falling pin edge |
| psc_bypass | input | 1 | 1: prescaler bypassed (1:1) |
| psc_rate | input | 3 | Divide code, ratio 2^(code+1) |
| irq_en | input | 1 | Interrupt enable |
| wr_cnt | input | 1 | Preload strobe |
| wr_data | input | 8 | Preload value |
| flag_clr | input | 1 | Clears the overflow flag |
| count | output | 8 | Current count |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that every control input except ext_pin is synchronous to clk and stays stable across the sampling edge. They also assume that cyc_en is a single-cycle qualifier and not a clock. ext_pin alone may change at any time, because the synchronizer absorbs it. The stimulus changes all inputs at the falling clock edge, and it changes the mode and rate controls only every few hundred cycles. Writes, clears and sleep are mixed in randomly at low rates, so the post-write lockout and the prescaler boundaries are both crossed many times.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

   typedef enum logic {
      SRC_CYCLE = 1'b0,
      SRC_PIN   = 1'b1
   } evt_src_e;

   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } evt_edge_e;

endpackage

// File: rtl/evt_pin_sync.sv
module evt_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic fall_sel,
   output logic edge_o
);
   import evt_timer_pkg::*;

   if (STAGES < 2) begin : g_bad_stages
      $error("evt_pin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;
   logic              rise, fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], pin};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   always_comb begin
      rise   = chain_q[STAGES-1] & ~prev_q;
      fall   = ~chain_q[STAGES-1] & prev_q;
      edge_o = (evt_edge_e'(fall_sel) == EDGE_FALL) ? fall : rise;
   end

endmodule

// File: rtl/evt_prescaler.sv
module evt_prescaler #(
   parameter int RATE_W  = 3,
   parameter bit HAS_PSC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              adv,
   input  logic              bypass,
   input  logic [RATE_W-1:0] rate,
   output logic              tick
);
   localparam int PSC_W = 1 << RATE_W;

   if (RATE_W < 1 || RATE_W > 4) begin : g_bad_rate
      $error("evt_prescaler: RATE_W must be within 1..4");
   end

   if (HAS_PSC) begin : g_psc
      logic [PSC_W-1:0] psc_q;
      logic [PSC_W:0]   ratio, ratio_m1;
      logic [PSC_W-1:0] term;
      logic             hit;

      always_comb begin
         ratio    = (PSC_W+1)'(2) << rate;
         ratio_m1 = ratio - (PSC_W+1)'(1);
         term     = ratio_m1[PSC_W-1:0];
         hit      = (psc_q >= term);
         tick     = adv & (bypass | hit);
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            psc_q <= '0;
         end else if (clr) begin
            psc_q <= '0;
         end else if (adv && !bypass) begin
            psc_q <= hit ? '0 : psc_q + 1'b1;
         end
      end
   end else begin : g_nopsc
      logic unused_psc_in;
      assign unused_psc_in = ^{clk, rst_n, clr, bypass, rate};
      assign tick = adv;
   end

endmodule

// File: rtl/evt_wr_hold.sv
module evt_wr_hold #(
   parameter int HOLD = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic cyc_en,
   output logic busy
);
   localparam int HW = $clog2(HOLD + 1);

   if (HOLD < 1) begin : g_bad_hold
      $error("evt_wr_hold: HOLD must be at least 1");
   end

   logic [HW-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
      end else if (load) begin
         hold_q <= HW'(HOLD);
      end else if (cyc_en && hold_q != '0) begin
         hold_q <= hold_q - 1'b1;
      end
   end

   assign busy = (hold_q != '0);

endmodule

// File: rtl/evt_timer8.sv
module evt_timer8 #(
   parameter int CNT_W       = 8,
   parameter int RATE_W      = 3,
   parameter bit HAS_PSC     = 1'b1,
   parameter int SYNC_STAGES = 2,
   parameter int WR_HOLD     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_en,
   input  logic              ext_pin,
   input  logic              sleep,
   input  logic              src_ext,
   input  logic              edge_fall,
   input  logic              psc_bypass,
   input  logic [RATE_W-1:0] psc_rate,
   input  logic              irq_en,
   input  logic              wr_cnt,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic              flag_clr,
   output logic [CNT_W-1:0]  count,
   output logic              ovf_flag,
   output logic              irq
);
   import evt_timer_pkg::*;

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   if (CNT_W < 2) begin : g_bad_cnt
      $error("evt_timer8: CNT_W must be at least 2");
   end

   logic pin_edge;
   logic hold_busy;
   logic src_evt;
   logic adv;
   logic tick;
   logic wrap;
   logic [CNT_W-1:0] cnt_q;
   logic flag_q;

   evt_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (ext_pin),
      .fall_sel (edge_fall),
      .edge_o   (pin_edge)
   );

   evt_wr_hold #(.HOLD(WR_HOLD)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (wr_cnt),
      .cyc_en (cyc_en),
      .busy   (hold_busy)
   );

   always_comb begin
      src_evt = (evt_src_e'(src_ext) == SRC_PIN) ? pin_edge : cyc_en;
      adv     = src_evt & ~sleep & ~hold_busy & ~wr_cnt;
   end

   evt_prescaler #(.RATE_W(RATE_W), .HAS_PSC(HAS_PSC)) u_psc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (wr_cnt),
      .adv    (adv),
      .bypass (psc_bypass),
      .rate   (psc_rate),
      .tick   (tick)
   );

   assign wrap = tick & (cnt_q == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (wr_cnt) begin
         cnt_q <= wr_data;
      end else if (tick) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else begin
         flag_q <= (flag_q & ~flag_clr) | wrap;
      end
   end

   assign count    = cnt_q;
   assign ovf_flag = flag_q;
   assign irq      = flag_q & irq_en;

endmodule

// File: rtl/evt_timer8_chk.sv
module evt_timer8_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sleep,
   input logic             irq_en,
   input logic             wr_cnt,
   input logic [CNT_W-1:0] wr_data,
   input logic             flag_clr,
   input logic [CNT_W-1:0] count,
   input logic             ovf_flag,
   input logic             irq,
   input logic             hold_busy
);
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   AST_RESET_STATE: assert property (@(posedge clk) $rose(rst_n) |-> (count == '0 && !ovf_flag)); // R1

   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_cnt |=> (count == $past(count) || count == CNT_W'($past(count) + 1'b1))); // R2

   AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt |=> count == $past(wr_data)); // R5

   AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_busy && !wr_cnt) |=> $stable(count)); // R6

   AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CMAX && !wr_cnt) ##1 (count == '0) |-> ovf_flag); // R7

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !flag_clr) |=> ovf_flag); // R8

   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ovf_flag && irq_en)); // R9

   AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && irq_en) |-> irq); // R9

   AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep && !wr_cnt) |=> $stable(count)); // R10

endmodule

bind evt_timer8 evt_timer8_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sleep     (sleep),
   .irq_en    (irq_en),
   .wr_cnt    (wr_cnt),
   .wr_data   (wr_data),
   .flag_clr  (flag_clr),
   .count     (count),
   .ovf_flag  (ovf_flag),
   .irq       (irq),
   .hold_busy (hold_busy)
);

// File: tb/evt_timer8_tb_top.sv
module evt_timer8_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cyc_en = 0, ext_pin = 0, sleep = 0, src_ext = 0, edge_fall = 0;
   logic       psc_bypass = 1, irq_en = 0, wr_cnt = 0, flag_clr = 0;
   logic [2:0] psc_rate = 0;
   logic [7:0] wr_data = 0;
   logic [7:0] count;
   logic       ovf_flag, irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   // reference state
   logic       m_s1 = 0, m_s2 = 0, m_s3 = 0;
   logic [7:0] m_cnt = 0;
   int         m_psc = 0;
   int         m_hold = 0;
   logic       m_flag = 0;

   always #5 clk = ~clk;

   evt_timer8 dut_i (
      .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ext_pin(ext_pin), .sleep(sleep),
      .src_ext(src_ext), .edge_fall(edge_fall), .psc_bypass(psc_bypass),
      .psc_rate(psc_rate), .irq_en(irq_en), .wr_cnt(wr_cnt), .wr_data(wr_data),
      .flag_clr(flag_clr), .count(count), .ovf_flag(ovf_flag), .irq(irq)
   );

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // next-state model built from the requirements, evaluated with the inputs of this cycle
   task automatic model_step();
      logic ev, ok, tk;
      int   ratio;
      ev = src_ext ? (edge_fall ? (~m_s2 & m_s3) : (m_s2 & ~m_s3)) : cyc_en;
      ok = ev && !sleep && (m_hold == 0) && !wr_cnt;
      tk = 0;
      if (ok) begin
         if (psc_bypass) tk = 1;
         else begin
            ratio = 2 << psc_rate;
            if (m_psc >= ratio - 1) begin m_psc = 0; tk = 1; end
            else m_psc++;
         end
      end
      m_flag = (m_flag & ~flag_clr) | (tk && m_cnt == 8'hFF);
      if (wr_cnt) begin
         m_cnt = wr_data; m_psc = 0; m_hold = 2;
      end else begin
         if (cyc_en && m_hold != 0) m_hold--;
         if (tk) m_cnt = m_cnt + 8'd1;
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
   endtask

   task automatic tick(string tag);
      model_step();
      @(posedge clk);
      #1;
      chk({tag, " count"}, count, m_cnt);
      chk({tag, " flag"}, ovf_flag, m_flag);
      chk({tag, " irq"}, irq, m_flag & irq_en);
      @(negedge clk);
      wr_cnt = 0; flag_clr = 0;
   endtask

   task automatic preload(logic [7:0] v);
      wr_cnt = 1; wr_data = v; tick("R5 preload");
      chk("R5 loaded value", count, v);
   endtask

   initial begin : watchdog
      #(200000 * 10);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'h5eed1234));
      repeat (3) @(negedge clk);
      chk("R1 reset count", count, 0);
      chk("R1 reset flag", ovf_flag, 0);
      chk("R1 reset irq", irq, 0);
      rst_n = 1;
      @(negedge clk);

      // R5 R6 R7 R9: preload FEh, lockout of two cycles, then wrap
      cyc_en = 1;
      preload(8'hFE);
      tick("R6 lockout 1"); chk("R6 held at FE", count, 8'hFE);
      tick("R6 lockout 2"); chk("R6 held at FE", count, 8'hFE);
      tick("R2 step");      chk("R2 FF", count, 8'hFF);
      tick("R7 wrap");      chk("R7 wrapped", count, 0);
      chk("R7 flag without irq_en", ovf_flag, 1);
      chk("R9 irq gated off", irq, 0);
      irq_en = 1; #1 chk("R9 irq on", irq, 1);
      cyc_en = 0;
      tick("R8 sticky"); chk("R8 still set", ovf_flag, 1);
      flag_clr = 1; tick("R8 clear"); chk("R8 cleared", ovf_flag, 0);

      // R8: clear coincident with wrap
      cyc_en = 1;
      preload(8'hFF);
      tick("R6 lock"); tick("R6 lock");
      flag_clr = 1; tick("R8 clr+wrap");
      chk("R8 flag kept on coincident clear", ovf_flag, 1);
      flag_clr = 1; tick("R8 clear");

      // R4: divide by 4 then by 256
      psc_bypass = 0; psc_rate = 3'd1;
      preload(8'h10);
      tick("R6"); tick("R6");
      repeat (3) tick("R4 div4");
      chk("R4 before 4th", count, 8'h10);
      tick("R4 div4"); chk("R4 after 4th", count, 8'h11);
      psc_rate = 3'd7;
      preload(8'h20);
      tick("R6"); tick("R6");
      repeat (255) tick("R4 div256");
      chk("R4 before 256th", count, 8'h20);
      tick("R4 div256"); chk("R4 after 256th", count, 8'h21);
      psc_bypass = 1;

      // R10: sleep freezes
      sleep = 1;
      repeat (10) tick("R10 sleep");
      chk("R10 frozen", count, 8'h21);
      sleep = 0;

      // R3: counter mode, rising then falling
      src_ext = 1; edge_fall = 0;
      preload(8'h00);
      tick("R6"); tick("R6");
      repeat (4) tick("R3 cyc_en ignored");
      chk("R3 no count from cyc_en", count, 0);
      ext_pin = 1;
      tick("R3 lat1"); tick("R3 lat2"); chk("R3 not yet", count, 0);
      tick("R3 lat3"); chk("R3 counted at third edge", count, 1);
      for (int i = 0; i < 3; i++) begin
         ext_pin = 0; repeat (3) tick("R3 low");
         ext_pin = 1; repeat (3) tick("R3 high");
      end
      chk("R3 rising count", count, 4);
      edge_fall = 1;
      for (int i = 0; i < 2; i++) begin
         ext_pin = 0; repeat (3) tick("R3 low");
         ext_pin = 1; repeat (3) tick("R3 high");
      end
      chk("R3 falling count", count, 6);

      // random mix
      for (int i = 0; i < 4000; i++) begin
         if (i % 250 == 0) begin
            src_ext = 1'($urandom); edge_fall = 1'($urandom);
            psc_bypass = 1'($urandom); psc_rate = 3'($urandom_range(0, 2));
            irq_en = 1'($urandom);
         end
         cyc_en   = 1'($urandom);
         if ($urandom_range(0, 2) == 0) ext_pin = ~ext_pin;
         sleep    = ($urandom_range(0, 9) == 0);
         wr_cnt   = ($urandom_range(0, 29) == 0);
         wr_data  = ($urandom_range(0, 1) == 0) ? 8'($urandom) : 8'hFC;
         flag_clr = ($urandom_range(0, 7) == 0);
         tick("R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule